// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when a DRAM controller sends refresh commands. An interval timer counts clock cycles and adds one owed refresh each time the average per-row spacing elapses. For example, a 64 ms retention window split over 8,192 rows gives 7.8125 µs. At 200 MHz that is about 1,562 cycles, and it is set through a parameter. Owed refreshes collect in a saturating pending counter. While the access path reports busy, refreshes are put off, so two issued refreshes can end up further apart than the average interval. The long-run rate still matches the timer.

When refreshes are owed and the access path is idle, the scheduler raises an access inhibit. It then waits for a grant and emits a one-cycle refresh strobe. After the strobe it keeps the inhibit high through the refresh recovery time. If the pending counter fills, the busy indication no longer holds the refresh back. The strobe carries no row address, because the DRAM steps its own internal row counter on every refresh.

The controller has four states, and each state drives the outputs as shown:

| State | Inhibit | Strobe |
|---|---|---|
| SCAN | low | low |
| CLAIM | high | low |
| STRIKE | high | high |
| SETTLE | high | low |

The transitions are:
- **SCAN → CLAIM**: taken when the counter is full, or when it is non-zero and the access path is not busy.
- **CLAIM → STRIKE**: taken on grant.
- **STRIKE → SETTLE**: taken always.
- **SETTLE → SCAN**: taken when the recovery count runs out.
- **Hold**: in every other case the state stays as it is.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ref_cmd_o` and `inhibit_o` are low.
- R2: One refresh becomes owed every `INTERVAL_CYC` cycles. With the access path idle and grant held high, the number of strobes over N intervals is N, with a tolerance of one.
- R3: While `busy_i` is high and fewer than `MAX_PEND` refreshes are owed, no refresh is started: `inhibit_o` stays low and no strobe appears.
- R4: Once `MAX_PEND` refreshes are owed, `inhibit_o` rises even while `busy_i` is high, and a refresh is issued after grant.
- R5: A strobe on `ref_cmd_o` appears only in the cycle after `grant_i` was sampled high with `inhibit_o` already high. While grant is low, the block waits with `inhibit_o` high.
- R6: `ref_cmd_o` is high for exactly one cycle per refresh. After the strobe, `inhibit_o` stays high for exactly `TRFC_CYC` more cycles and then goes low for at least one cycle.
- R7: The pending count saturates at `MAX_PEND`, and intervals that elapse while it is full are dropped. After a long grant stall, exactly `MAX_PEND` refreshes are issued back to back.
- R8: When the access path goes idle with K owed refreshes (K < `MAX_PEND`), K strobes follow, spaced `TRFC_CYC`+3 cycles apart. No further strobes follow until the next interval elapses.
- R9: Under an irregular busy pattern, the strobe count over a long run differs from the number of elapsed intervals by at most `MAX_PEND`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Access path has work in flight or waiting |
| grant_i | input | 1 | Command slot granted to the refresh |
| ref_cmd_o | output | 1 | One-cycle refresh command strobe |
| inhibit_o | output | 1 | Normal accesses must not be issued |

## Verification
The interval timer can add an owed refresh in the same cycle that a strobe removes one. The counter must then stay where it is instead of gaining or losing a count. Long idle runs and runs with a pseudo-random busy pattern let these coincidences happen many times. They are judged by comparing the total strobe count with the number of intervals the bench has timed. A second overlap is an interval ending while the counter is already full and the grant is withheld. This is provoked by stalling the grant for many intervals. It is judged by counting exactly `MAX_PEND` strobes in the drain that follows.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
    typedef enum logic [1:0] {
        SCAN   = 2'd0,
        CLAIM  = 2'd1,
        STRIKE = 2'd2,
        SETTLE = 2'd3
    } rs_state_t;
endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int INTERVAL_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick_o = (cnt_q == LAST);

    // R2: ticks are separated by a full interval
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && INTERVAL_CYC > 1) |=> !tick_o);
endmodule

// File: rtl/refsched_pending.sv
module refsched_pending #(
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add_i,
    input  logic take_i,
    output logic nz_o,
    output logic full_o
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] TOP = PW'(MAX_PEND);

    logic [PW-1:0] owed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            unique case ({add_i, take_i})
                2'b10:   if (owed_q != TOP) owed_q <= owed_q + PW'(1);
                2'b01:   owed_q <= owed_q - PW'(1);
                default: owed_q <= owed_q;
            endcase
        end
    end

    assign nz_o   = (owed_q != '0);
    assign full_o = (owed_q == TOP);

    // R7: a full counter hit by a lone interval stays full
    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && add_i && !take_i) |=> full_o);
    // R8: a refresh is only taken when one is owed
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> nz_o);
endmodule

// File: rtl/refsched_fsm.sv
module refsched_fsm
    import refsched_pkg::*;
#(
    parameter int TRFC_CYC = 52
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic grant_i,
    input  logic owed_i,
    input  logic full_i,
    output logic fire_o,
    output logic inhibit_o
);
    localparam int RW = $clog2(TRFC_CYC + 1);
    localparam logic [RW-1:0] RLOAD = RW'(TRFC_CYC - 1);

    rs_state_t     state_q, state_d;
    logic [RW-1:0] rfc_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN:   if (full_i || (owed_i && !busy_i)) state_d = CLAIM;
            CLAIM:  if (grant_i) state_d = STRIKE;
            STRIKE: state_d = SETTLE;
            SETTLE: if (rfc_q == '0) state_d = SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN;
            rfc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == STRIKE) begin
                rfc_q <= RLOAD;
            end else if (state_q == SETTLE && rfc_q != '0) begin
                rfc_q <= rfc_q - RW'(1);
            end
        end
    end

    always_comb begin
        fire_o    = 1'b0;
        inhibit_o = 1'b0;
        unique case (state_q)
            SCAN:   inhibit_o = 1'b0;
            CLAIM:  inhibit_o = 1'b1;
            STRIKE: begin
                inhibit_o = 1'b1;
                fire_o    = 1'b1;
            end
            SETTLE: inhibit_o = 1'b1;
        endcase
    end

    // R5: strobe only after a sampled grant
    assert_grant_before_strike_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> ($past(grant_i) && $past(inhibit_o)));
    // R6: strobe is a single cycle and inhibit survives it
    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (!fire_o && inhibit_o));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int INTERVAL_CYC = 1562,
    parameter int MAX_PEND     = 8,
    parameter int TRFC_CYC     = 52
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic grant_i,
    output logic ref_cmd_o,
    output logic inhibit_o
);
    logic tick;
    logic owed;
    logic full;
    logic fire;

    refsched_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    refsched_pending #(.MAX_PEND(MAX_PEND)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_i  (tick),
        .take_i (fire),
        .nz_o   (owed),
        .full_o (full)
    );

    refsched_fsm #(.TRFC_CYC(TRFC_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (busy_i),
        .grant_i   (grant_i),
        .owed_i    (owed),
        .full_i    (full),
        .fire_o    (fire),
        .inhibit_o (inhibit_o)
    );

    assign ref_cmd_o = fire;

    // R3: a busy path with room left keeps the refresh deferred
    assert_hold_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit_o && busy_i && !full) |=> !inhibit_o);
    // R4: a full counter claims the interface regardless of busy
    assert_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit_o && full) |=> inhibit_o);
    // R1: nothing is issued in the cycle following reset
    assert_quiet_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !ref_cmd_o);
endmodule

// File: tb/refresh_sched_tb.sv
`timescale 1ns/100ps
module refresh_sched_tb;
    localparam int IV   = 64;
    localparam int MAXP = 4;
    localparam int TRFC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy_i = 1'b0;
    logic grant_i = 1'b0;
    logic ref_cmd_o;
    logic inhibit_o;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit measuring = 1'b0;
    int rc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    refresh_sched #(.INTERVAL_CYC(IV), .MAX_PEND(MAXP), .TRFC_CYC(TRFC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (busy_i),
        .grant_i   (grant_i),
        .ref_cmd_o (ref_cmd_o),
        .inhibit_o (inhibit_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Continuous monitor, sampled away from the active edge (R6)
    always @(negedge clk) begin
        if (!rst_n) begin
            measuring <= 1'b0;
        end else if (ref_cmd_o) begin
            strobes <= strobes + 1;
            if (measuring) chk(1'b0, "R6 strobe width/overlap", rc, TRFC);
            measuring <= 1'b1;
            rc <= 0;
        end else if (measuring) begin
            if (inhibit_o) begin
                rc <= rc + 1;
            end else begin
                chk(rc == TRFC, "R6 inhibit after strobe", rc, TRFC);
                measuring <= 1'b0;
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input bit b, input bit g);
        @(posedge clk); #1;
        rst_n = 1'b0; busy_i = b; grant_i = g;
        cycles(3);
        @(negedge clk);
        chk(ref_cmd_o == 1'b0 && inhibit_o == 1'b0, "R1 outputs in reset",
            {ref_cmd_o, inhibit_o}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset(1'b0, 1'b1);
        @(negedge clk);
        chk(ref_cmd_o == 1'b0 && inhibit_o == 1'b0, "R1 first cycle after reset",
            {ref_cmd_o, inhibit_o}, 0);
    endtask

    task automatic t_postpone_drain;
        int s0;
        do_reset(1'b1, 1'b1);
        s0 = strobes;
        cycles((MAXP - 1) * IV + 2);
        @(negedge clk);
        chk(strobes - s0 == 0, "R3 no refresh while busy", strobes - s0, 0);
        chk(inhibit_o == 1'b0, "R3 inhibit low while busy", inhibit_o, 0);
        busy_i = 1'b0;
        cycles((MAXP - 1) * (TRFC + 3) + 4);
        @(negedge clk);
        chk(strobes - s0 == MAXP - 1, "R8 drain of postponed refreshes",
            strobes - s0, MAXP - 1);
        cycles(10);
        @(negedge clk);
        chk(strobes - s0 == MAXP - 1 && inhibit_o == 1'b0, "R8 quiet after drain",
            strobes - s0, MAXP - 1);
    endtask

    task automatic t_forced;
        int s0;
        do_reset(1'b1, 1'b1);
        s0 = strobes;
        cycles(MAXP * IV + IV / 2);
        @(negedge clk);
        chk(strobes - s0 == 1, "R4 forced refresh under busy", strobes - s0, 1);
    endtask

    task automatic t_grant_wait;
        int s0;
        do_reset(1'b0, 1'b0);
        s0 = strobes;
        cycles(2 * IV + IV / 2);
        @(negedge clk);
        chk(strobes - s0 == 0, "R5 no strobe without grant", strobes - s0, 0);
        chk(inhibit_o == 1'b1, "R5 inhibit held while waiting", inhibit_o, 1);
        grant_i = 1'b1;
        cycles(2 * (TRFC + 3) + 4);
        @(negedge clk);
        chk(strobes - s0 == 2, "R5 strobes after grant", strobes - s0, 2);
    endtask

    task automatic t_saturate;
        int s0;
        do_reset(1'b0, 1'b0);
        cycles(12 * IV);
        s0 = strobes;
        grant_i = 1'b1;
        cycles(MAXP * (TRFC + 3) + 6);
        @(negedge clk);
        chk(strobes - s0 == MAXP, "R7 saturated drain count", strobes - s0, MAXP);
    endtask

    task automatic t_long_idle;
        int s0, d;
        do_reset(1'b0, 1'b1);
        s0 = strobes;
        cycles(25 * IV + 4);
        @(negedge clk);
        d = strobes - s0;
        chk(d >= 24 && d <= 26, "R2 long-run rate idle", d, 25);
    endtask

    task automatic t_long_busy;
        int s0, d;
        logic [7:0] lfsr;
        do_reset(1'b0, 1'b1);
        s0 = strobes;
        lfsr = 8'hA5;
        for (int i = 0; i < 40 * IV / 16; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            busy_i = lfsr[0] | lfsr[1];
            cycles(16);
        end
        @(negedge clk);
        d = strobes - s0;
        chk(d >= 40 - MAXP && d <= 40 + 1, "R9 long-run rate under busy", d, 40);
    endtask

    initial begin
        t_reset();
        t_postpone_drain();
        t_forced();
        t_grant_wait();
        t_saturate();
        t_long_idle();
        t_long_busy();
        cycles(20);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule